// File: doc/BRIEF.md
# Carry-Skip Block Adder

This block adds two unsigned operands and a single carry-in with no clock. The operand width is split into equal groups of bits. Inside each group the carry ripples from bit to bit through a chain of full-adder cells. Each group also has a skip multiplexer. When every bit of a group would pass its incoming carry through unchanged, the multiplexer sends the group's incoming carry straight to the next group and does not wait for the ripple chain.

Each bit is classified from its two operand bits alone, as generate, propagate or delete. A group's skip select is the AND of its bits' propagate terms. The per-group skip selects are brought out as a debug vector, which shows which groups took the short path for the current operands. The total width and the group size are parameters. The default is 16 bits in four groups of 4. The result is always {carry_out, sum_o} = op_a + op_b + carry_in.

Top module: `cskip_adder`

## Requirements
- R1: For every bit i, exactly one of three classes holds: generate (op_a[i] AND op_b[i]), propagate (op_a[i] XOR op_b[i]) or delete (NOT op_a[i] AND NOT op_b[i]).
- R2: skip_o[k] is 1 exactly when op_a[i] XOR op_b[i] is 1 for every bit i in group k. Group k covers bits k*M up to k*M+M-1, so skip_o bit 0 belongs to the lowest group.
- R3: When a group's skip select is 1, the carry it passes to the next group equals the carry that enters it. A carry from lower groups then reaches the higher groups.
- R4: When a group's skip select is 0, its outgoing carry is the ripple result. A generate in the group's top bit forces that carry to 1, and a delete in the top bit forces it to 0.
- R5: sum_o[i] = op_a[i] XOR op_b[i] XOR c[i], where c[i] is the carry into bit i. As a result, {carry_out, sum_o} = op_a + op_b + carry_in for every input.
- R6: carry_out is the outgoing carry of the highest group. When every group skips, carry_out equals carry_in.
- R7: N must be a whole multiple of M. A mismatch stops elaboration, and the block has N/M groups (4 by default).
- R8: The block is purely combinational. Its outputs follow a change of the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |
| skip_o | output | N/M | Skip select of each group, lowest group in bit 0 |

## Verification
The fixed vectors cover the following operand patterns:
- All-zero, all-one and alternating operand patterns that make every group skip or none skip.
- Single-nibble propagate masks that make exactly one or two groups skip.
- A carry born in group 0 that must cross two skipping groups to reach group 3.

These patterns separate a wrong skip select, a multiplexer wired to the wrong carry and a broken ripple. Generate and delete in a group's top bit show whether the non-skip path forces the carry correctly. Two thousand random operand pairs are compared with a plain behavioural sum, and the expected skip vector is computed from the operands. Together they expose any mismatch in sum, carry or grouping that the fixed cases miss.

// File: rtl/cskip_pkg.sv
package cskip_pkg;
    // Per-bit classification of an operand pair
    typedef struct packed {
        logic gen;
        logic prop;
        logic del;
    } bit_class_t;
endpackage

// File: rtl/cskip_bit_class.sv
module cskip_bit_class
    import cskip_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    output bit_class_t cls_o
);
    always_comb begin
        cls_o.gen  = a_i & b_i;
        cls_o.prop = a_i ^ b_i;
        cls_o.del  = ~a_i & ~b_i;
    end
endmodule

// File: rtl/cskip_group.sv
module cskip_group
    import cskip_pkg::*;
#(
    parameter int M = 4
) (
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    input  logic         cin_i,
    output logic [M-1:0] sum_o,
    output logic         cout_o,
    output logic         skip_o
);
    typedef struct packed {
        logic [M:0]   chain;
        logic [M-1:0] sum;
        logic         skip;
        logic         cout;
    } grp_t;

    bit_class_t cls [M];
    logic [M-1:0] gen_v, prop_v, del_v;
    grp_t grp_d;

    for (genvar i = 0; i < M; i++) begin : g_bit
        cskip_bit_class u_cls (.a_i(a_i[i]), .b_i(b_i[i]), .cls_o(cls[i]));
        assign gen_v[i]  = cls[i].gen;
        assign prop_v[i] = cls[i].prop;
        assign del_v[i]  = cls[i].del;
    end

    always_comb begin
        grp_d          = '0;
        grp_d.chain[0] = cin_i;
        for (int i = 0; i < M; i++) begin
            grp_d.chain[i+1] = gen_v[i] | (prop_v[i] & grp_d.chain[i]);
            grp_d.sum[i]     = prop_v[i] ^ grp_d.chain[i];
        end
        grp_d.skip = &prop_v;
        grp_d.cout = grp_d.skip ? cin_i : grp_d.chain[M];

        if (!$isunknown({a_i, b_i, cin_i})) begin
            for (int i = 0; i < M; i++) begin
                assert_one_class_R1: assert ($onehot({gen_v[i], prop_v[i], del_v[i]}))
                    else $error("bit %0d not in exactly one class", i);
            end
            assert_skip_agrees_ripple_R3: assert (!grp_d.skip || (grp_d.chain[M] == cin_i))
                else $error("skip taken but ripple disagrees");
            assert_top_gen_R4: assert (!gen_v[M-1] || grp_d.cout)
                else $error("top generate lost");
            assert_top_del_R4: assert (!del_v[M-1] || !grp_d.cout)
                else $error("top delete lost");
        end
    end

    assign sum_o  = grp_d.sum;
    assign cout_o = grp_d.cout;
    assign skip_o = grp_d.skip;
endmodule

// File: rtl/cskip_adder.sv
module cskip_adder #(
    parameter int N = 16,
    parameter int M = 4
) (
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    input  logic           carry_in,
    output logic [N-1:0]   sum_o,
    output logic           carry_out,
    output logic [N/M-1:0] skip_o
);
    localparam int G = N / M;

    // R7: width must split into whole groups
    if ((N % M) != 0 || M < 1) begin : g_bad_split
        $error("N must be a whole multiple of M");
    end

    logic [G:0] carry_q;
    assign carry_q[0] = carry_in;

    for (genvar k = 0; k < G; k++) begin : g_grp
        cskip_group #(.M(M)) u_grp (
            .a_i   (op_a[k*M +: M]),
            .b_i   (op_b[k*M +: M]),
            .cin_i (carry_q[k]),
            .sum_o (sum_o[k*M +: M]),
            .cout_o(carry_q[k+1]),
            .skip_o(skip_o[k])
        );
    end

    assign carry_out = carry_q[G];

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            assert_all_skip_passes_R6: assert (!(&skip_o) || (carry_out == carry_in))
                else $error("all groups skip but carry_out differs from carry_in");
        end
    end
endmodule

// File: tb/cskip_adder_tb.sv
module cskip_adder_tb;
    localparam int N = 16;
    localparam int M = 4;
    localparam int G = N / M;

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
        logic [16:0] res;
        logic [3:0]  skip;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{16'h0000, 16'h0000, 1'b0, 17'h00000, 4'h0},
        '{16'hFFFF, 16'h0000, 1'b1, 17'h10000, 4'hF},
        '{16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF, 4'hF},
        '{16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, 4'h0},
        '{16'h1234, 16'h4321, 1'b0, 17'h05555, 4'h0},
        '{16'h0F0F, 16'hF0F0, 1'b1, 17'h10000, 4'hF},
        '{16'h00F0, 16'h0010, 1'b0, 17'h00100, 4'h0},
        '{16'hA5A5, 16'h5A5A, 1'b0, 17'h0FFFF, 4'hF},
        '{16'h8000, 16'h8000, 1'b0, 17'h10000, 4'h0},
        '{16'h0F00, 16'h0000, 1'b1, 17'h00F01, 4'h4},
        '{16'h7FFF, 16'h0001, 1'b0, 17'h08000, 4'h6},
        '{16'h0FFF, 16'h0001, 1'b0, 17'h01000, 4'h6}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [N-1:0] op_a, op_b, sum_o;
    logic carry_in, carry_out;
    logic [G-1:0] skip_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    cskip_adder #(.N(N), .M(M)) u_dut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum_o(sum_o), .carry_out(carry_out), .skip_o(skip_o)
    );

    function automatic logic [G-1:0] skip_ref(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N-1:0] p;
        p = a ^ b;
        for (int k = 0; k < G; k++) skip_ref[k] = &p[k*M +: M];
    endfunction

    task automatic check_res(input string req, input logic [N:0] exp_res);
        checks++;
        if ({carry_out, sum_o} !== exp_res) begin
            errors++;
            $display("FAIL %s: a=%h b=%h cin=%b got=%h exp=%h", req, op_a, op_b, carry_in,
                     {carry_out, sum_o}, exp_res);
        end
    endtask

    task automatic check_skip(input string req, input logic [G-1:0] exp_skip);
        checks++;
        if (skip_o !== exp_skip) begin
            errors++;
            $display("FAIL %s: a=%h b=%h skip got=%b exp=%b", req, op_a, op_b, skip_o, exp_skip);
        end
    endtask

    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input logic c);
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c;
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        op_a = '0; op_b = '0; carry_in = 1'b0;
        #1;
        // Initial state with zero inputs (R8: settles with no clock edge)
        check_res("R8 zero inputs", '0);
        check_skip("R2 zero inputs", '0);

        // R7: default split gives four groups
        checks++;
        if ($bits(skip_o) != 4) begin
            errors++;
            $display("FAIL R7: got=%0d groups exp=4", $bits(skip_o));
        end

        // Vector table: R2, R3, R5, R6
        foreach (VECS[i]) begin
            drive(VECS[i].a, VECS[i].b, VECS[i].cin);
            check_res("R5 R6 table", VECS[i].res);
            check_skip("R2 table", VECS[i].skip);
        end

        // R3: carry from group 0 crosses skipping groups 1 and 2
        drive(16'h0FFF, 16'h0001, 1'b0);
        check_res("R3 carry crosses skipping groups", 17'h01000);
        // R3: all skip, carry_in travels to carry_out (R6)
        drive(16'h5555, 16'hAAAA, 1'b1);
        check_res("R3 R6 full skip", 17'h10000);
        // R4: generate in group 0 top bit
        drive(16'h0008, 16'h0008, 1'b0);
        check_res("R4 top generate", 17'h00010);
        // R4: delete in top bit stops carry
        drive(16'h0007, 16'h0001, 1'b0);
        check_res("R4 top delete", 17'h00008);
        // R1: mixed classes per bit, result must still be exact
        drive(16'h00C6, 16'h00A3, 1'b1);
        check_res("R1 mixed classes", 17'h0016A);

        // R8: input change with no clock edge in between
        @(posedge clk); #0.5;
        op_a = 16'h1111; op_b = 16'h2222; carry_in = 1'b0;
        #0.5;
        check_res("R8 no clock edge", 17'h03333);

        // R5 random comparison against behavioural sum
        for (int n = 0; n < 2000; n++) begin
            logic [N-1:0] ra, rb;
            logic rc;
            ra = N'($urandom);
            rb = N'($urandom);
            rc = 1'($urandom);
            if (n % 4 == 0) rb = ~ra ^ N'($urandom_range(0, 15) << (4 * (n % G)));
            drive(ra, rb, rc);
            check_res("R5 random", {1'b0, ra} + {1'b0, rb} + {{N{1'b0}}, rc});
            check_skip("R2 random", skip_ref(ra, rb));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule